// File: doc/BRIEF.md
# Keyed-Reload Watchdog Timer

A bus-attached watchdog for a motion or I/O controller. The host loads a 31-bit timeout count and must keep writing a fixed key byte to a pet register before the count runs out. When the countdown expires, a sticky expired flag is set and a safe-state `bite` output rises. The flag stays set until the host explicitly clears it.

The block has a 32-bit word-addressed register port. Writes take effect on the clock edge. Reads are combinational from the current address. Four words are decoded:

| Word | Register | Behaviour |
|------|----------|-----------|
| 0 | timeout | read/write |
| 1 | status | expired flag in bit 0 |
| 2 | pet | write-only, reads 0 |
| 3 | unused | reads 0, writes ignored |

While the flag is set, the counter is frozen and pets are refused. Clearing the flag restarts the countdown from the timeout register.

Top module: `wdog_petkey`

## Requirements
- R1: After reset, `bite` is 0, status (word 1) reads 0, and the timeout register (word 0) reads the parameter `INIT_TIMEOUT`.
- R2: A write to word 0 stores bits [30:0] of the data. Reading word 0 returns the stored value with bit 31 always 0. Writing 0xFFFFFFFF therefore reads back 0x7FFFFFFF.
- R3: After a reload with value L, `bite` rises on the (L+1)th clock edge after the reloading edge. A value of 0 expires on the first edge.
- R4: A write to word 2 whose bits [31:24] equal 0x5A reloads the counter from the timeout register. Bits [23:0] of that write are not examined.
- R5: A write to word 2 whose bits [31:24] are not 0x5A has no effect on the countdown.
- R6: Expiry sets status bit 0, and `bite` is a registered copy of it. Both stay at 1 until a clear.
- R7: While expired, the counter holds and key writes to word 2 are ignored. A clear reloads the counter, so the next expiry follows R3.
- R8: Writing the full word 0x00000000 to word 1 clears the expired flag. Any nonzero write to word 1 is ignored.
- R9: A write to word 0 does not restart a countdown in progress. The new value is used from the next reload on.
- R10: Words 2 and 3 read 0. A write to word 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | free-running clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_we | input | 1 | write strobe, one write per cycle |
| bus_addr | input | 2 | word address |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data for `bus_addr` |
| bite | output | 1 | safe-state output, high while expired |

## Verification
The bound checker checks the following on every cycle:
- the status read agrees with `bite`;
- the flag stays set until a zero write to word 1, and that write clears it;
- a correct key reloads the counter from the timeout register;
- a wrong key lets the countdown continue;
- the counter is frozen while expired;
- expiry follows a zero count;
- words 2 and 3 read 0.

The exact L+1 timeout length, the deferred effect of a timeout write on a running countdown, and the clear-then-re-expire sequence take several writes in a row. Only the bench scenarios show these, with its reference model tracking every cycle.

// File: rtl/wdog_petkey.sv
module wdog_petkey #(
  parameter int unsigned CNT_W = 31,
  parameter logic [CNT_W-1:0] INIT_TIMEOUT = CNT_W'(1000),
  parameter logic [7:0] PET_KEY = 8'h5A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bite
);
  localparam int unsigned PAD_W = 32 - CNT_W;

  logic [CNT_W-1:0] load_q, cnt_q;
  logic             bit_q;

  wire wr_tmr = bus_we && bus_addr == 2'd0;
  wire clr    = bus_we && bus_addr == 2'd1 && bus_wdata == 32'd0;
  wire pet    = bus_we && bus_addr == 2'd2 && bus_wdata[31:24] == PET_KEY;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= INIT_TIMEOUT;
      cnt_q  <= INIT_TIMEOUT;
      bit_q  <= 1'b0;
    end else begin
      if (wr_tmr) load_q <= bus_wdata[CNT_W-1:0];
      if (clr) begin
        bit_q <= 1'b0;
        cnt_q <= load_q;
      end else if (!bit_q) begin
        if (pet)              cnt_q <= load_q;
        else if (cnt_q == '0) bit_q <= 1'b1;
        else                  cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {{PAD_W{1'b0}}, load_q};
      2'd1:    bus_rdata = {31'd0, bit_q};
      default: bus_rdata = 32'd0;
    endcase
  end

  assign bite = bit_q;
endmodule

module wdog_petkey_chk #(
  parameter int unsigned CW = 31,
  parameter logic [7:0] KEY = 8'h5A
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [1:0]    bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic          bite,
  input logic [CW-1:0] count,
  input logic [CW-1:0] load_val
);
  wire c_clr  = bus_we && bus_addr == 2'd1 && bus_wdata == 32'd0;
  wire c_pet  = bus_we && bus_addr == 2'd2 && bus_wdata[31:24] == KEY;
  wire c_bad  = bus_we && bus_addr == 2'd2 && bus_wdata[31:24] != KEY;

  AST_STATUS_IS_BITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 2'd1 |-> bus_rdata == {31'd0, bite}); // R6
  AST_BITE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    bite && !c_clr |=> bite); // R6
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    c_clr |=> !bite); // R8
  AST_UPPER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr[1] |-> bus_rdata == 32'd0); // R10
  AST_TIMER_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 2'd0 |=> bus_addr != 2'd0 || bus_rdata == {1'b0, $past(bus_wdata[30:0])}); // R2
  AST_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    !bite && count == '0 && !c_pet && !c_clr |=> bite); // R3
  AST_RISE_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bite) |-> $past(count) == '0); // R3
  AST_PET_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    !bite && c_pet |=> count == $past(load_val)); // R4
  AST_BAD_KEY_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    !bite && c_bad && count != '0 |=> count == $past(count) - 1'b1); // R5
  AST_HOLD_WHILE_BITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    bite && !c_clr |=> $stable(count)); // R7
endmodule

bind wdog_petkey wdog_petkey_chk #(.CW(CNT_W), .KEY(PET_KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bite(bite),
  .count(cnt_q), .load_val(load_q)
);

// File: tb/sim_wdog_petkey.sv
module sim_wdog_petkey;
  localparam int CLK_P = 10;
  localparam logic [31:0] KEYW = 32'h5A00_0000;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0, bus_rdata;
  logic bite;
  int compared = 0, mismatched = 0;

  wdog_petkey #(.INIT_TIMEOUT(31'd20)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bite(bite)
  );

  always #(CLK_P/2) clk = ~clk;

  // reference model
  longint m_load, m_cnt;
  bit m_bit;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_load = 20; m_cnt = 20; m_bit = 0;
    end else begin
      if (bus_we && bus_addr == 1 && bus_wdata == 0) begin
        m_bit = 0; m_cnt = m_load;
      end else if (!m_bit) begin
        if (bus_we && bus_addr == 2 && bus_wdata[31:24] == 8'h5A) m_cnt = m_load;
        else if (m_cnt == 0) m_bit = 1;
        else m_cnt = m_cnt - 1;
      end
      if (bus_we && bus_addr == 0) m_load = longint'(bus_wdata & 32'h7FFF_FFFF);
    end
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h @%0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [31:0] e;
    case (bus_addr)
      2'd0: e = 32'(m_load);
      2'd1: e = {31'd0, m_bit};
      default: e = 32'd0;
    endcase
    chk("R6 bite", {31'd0, bite}, {31'd0, m_bit});
    chk("R2/R10 rdata", bus_rdata, e);
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(posedge clk); #2;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_we = 1'b0; bus_wdata = 32'd0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #(CLK_P * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] v;
    edges(3); rst_n = 1'b1;
    rd(0, v); chk("R1 timer", v, 32'd20);
    rd(1, v); chk("R1 status", v, 32'd0);
    chk("R1 bite", {31'd0, bite}, 32'd0);
    // R4: regular petting, low bits of key word ignored
    for (int i = 0; i < 4; i++) begin
      edges(10);
      wr(2, (i % 2) ? 32'h5AFF_FFFF : KEYW);
    end
    chk("R4 no bite while petted", {31'd0, bite}, 32'd0);
    // R2
    wr(0, 32'hFFFF_FFFF); rd(0, v); chk("R2 bit31 dropped", v, 32'h7FFF_FFFF);
    wr(0, 32'd5); rd(0, v); chk("R2 readback", v, 32'd5);
    // R3: pet with 5 -> bite on 6th edge
    wr(2, KEYW);
    edges(5); chk("R3 before L+1", {31'd0, bite}, 32'd0);
    edges(1); chk("R3 at L+1", {31'd0, bite}, 32'd1);
    rd(1, v); chk("R6 status set", v, 32'd1);
    // R7: pets ignored while bitten
    wr(2, KEYW); edges(10); chk("R7 pet ignored", {31'd0, bite}, 32'd1);
    // R8: nonzero status write ignored, zero clears
    wr(1, 32'd1); edges(2); chk("R8 nonzero ignored", {31'd0, bite}, 32'd1);
    wr(1, 32'd0); chk("R8 cleared", {31'd0, bite}, 32'd0);
    edges(5); chk("R7 reload on clear", {31'd0, bite}, 32'd0);
    edges(1); chk("R7 re-expire", {31'd0, bite}, 32'd1);
    // R5: wrong keys at clear+2 and clear+4 do not delay expiry at clear+6
    wr(1, 32'd0);
    wr(2, 32'h005A_0000);
    wr(2, 32'hA500_0000);
    edges(1); chk("R5 bad key", {31'd0, bite}, 32'd0);
    edges(1); chk("R5 bad key expiry", {31'd0, bite}, 32'd1);
    // R9: timer write during countdown is deferred
    wr(1, 32'd0);
    wr(0, 32'd30);
    edges(3); chk("R9 old count", {31'd0, bite}, 32'd0);
    edges(1); chk("R9 old count expiry", {31'd0, bite}, 32'd1);
    wr(1, 32'd0);
    edges(30); chk("R9 new count", {31'd0, bite}, 32'd0);
    edges(1); chk("R9 new count expiry", {31'd0, bite}, 32'd1);
    // R10
    rd(2, v); chk("R10 word2", v, 32'd0);
    rd(3, v); chk("R10 word3", v, 32'd0);
    wr(3, 32'hFFFF_FFFF);
    rd(0, v); chk("R10 timer untouched", v, 32'd30);
    rd(1, v); chk("R10 status untouched", v, 32'd1);
    // R3: zero timeout
    wr(0, 32'd0); wr(1, 32'd0);
    chk("R3 zero cleared", {31'd0, bite}, 32'd0);
    edges(1); chk("R3 zero expiry", {31'd0, bite}, 32'd1);
    edges(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule